// File: doc/BRIEF.md
# Bus Activity Lamp and Serial ID Loader

This block owns one active-low output pin and uses it for three jobs in turn. When the bus reset is released, the pin first runs as a serial clock at half the system clock rate. Over sixteen clock periods it shifts in an external device identifier from a serial data input. That identifier then replaces a built-in default. On the fourth rising transition of that clock, the block also captures a mode-select input as the memory-port mode bit. While the load runs, a retry flag tells the bus front end to turn away target accesses.

Once the load is done, the pin is held low without a break to show that normal run mode has been reached. It stays low until software issues a clear pulse. After that, the pin acts as a bus-activity lamp. Any of three selection status flags latches it low, and the next bus-free indication releases it. A software general-purpose bit can take over the pin at any time after the load.

Top module: `status_lamp_ctrl`

## Requirements
- R1: While `rst` is high, and in the cycle after each clock edge that sampled it high, `lamp_oe` is 0, `lamp_n` is 1, `retry` is 0, `id_valid` is 0, `mport_mode` is 0 and `id_value` equals `DEFAULT_ID`.
- R2: From the first clock edge after reset release, `lamp_n` is driven (`lamp_oe`=1). It goes low for one cycle and then high for one cycle, repeated, giving exactly `ID_W` (16) low-to-high transitions. It then leaves shift mode.
- R3: On each low-to-high transition of `lamp_n`, `id_sdata` is sampled, most significant bit first. `id_value` shows `DEFAULT_ID` until the last bit is taken. From then on, `id_value` holds the sixteen captured bits and `id_valid` is 1.
- R4: `mode_sel` is captured into `mport_mode` on the fourth low-to-high transition only. Its level at any other time has no effect.
- R5: `retry` is 1 from the first edge after reset release until shift mode ends, which is 2×`ID_W` cycles. It is 0 at all other times.
- R6: After shift mode, `lamp_n` is held at 0 whatever `sel_flags` and `bus_free` do, until a cycle with `sw_run_clr`=1.
- R7: After that clear, `lamp_n` goes to 0 on the edge that samples any bit of `sel_flags` high. It stays 0 after the flag drops, and returns to 1 on the edge that samples `bus_free` high. The flag bits are: bit 0 selection in progress, bit 1 selected as target, bit 2 selected as initiator.
- R8: If any `sel_flags` bit and `bus_free` are high in the same cycle, the lamp is set (`lamp_n`=0).
- R9: After shift mode, `sw_gp_en`=1 makes `lamp_n` equal to the inverse of `sw_gp_val` on the next edge, in both run and activity modes. During shift mode `sw_gp_en` has no effect on the clock pattern.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock (shift clock is half this rate) |
| rst | input | 1 | Synchronous active-high bus reset |
| sel_flags | input | 3 | Selection status: [0] in progress, [1] selected-in, [2] selected-out |
| bus_free | input | 1 | Bus-free detect, clears the activity latch |
| id_sdata | input | 1 | Serial identifier data |
| mode_sel | input | 1 | Memory-port mode select, sampled on 4th shift rise |
| sw_run_clr | input | 1 | Software pulse ending the run-mode indication |
| sw_gp_en | input | 1 | Software takes over the pin |
| sw_gp_val | input | 1 | Software pin request, 1 lights the lamp (pin low) |
| lamp_n | output | 1 | Active-low multi-use pin value |
| lamp_oe | output | 1 | Pin output enable, 0 floats the pin |
| id_value | output | 16 | Identifier in use (default or captured) |
| id_valid | output | 1 | Captured identifier has replaced the default |
| mport_mode | output | 1 | Captured memory-port mode bit |
| retry | output | 1 | Target accesses must be retried |

## Verification
The bench counts the pin's rising transitions and the retry cycles during the load. A design with an off-by-one bit counter would give 15 or 17 clock periods, a retry window of the wrong length, or an identifier shifted by one bit. The mode input is driven opposite to the wanted value on every shift period except the fourth, in both polarities, so a sampling slot that is one early or one late shows up as the wrong mode bit. The run-mode hold is tested with activity and bus-free pulses, which a design that entered activity mode too soon would pass through to the pin. The priority test raises a status flag and bus-free together, which catches a latch where the clear wins. Software override is held on during a whole load to show that it cannot disturb the shift clock.

// File: rtl/lamp_pkg.sv
package lamp_pkg;
  typedef enum logic [1:0] {
    PH_IDLE  = 2'd0,
    PH_SHIFT = 2'd1,
    PH_RUN   = 2'd2,
    PH_ACT   = 2'd3
  } lamp_phase_e;
endpackage

// File: rtl/lamp_seq.sv
module lamp_seq
  import lamp_pkg::*;
#(
  parameter int ID_W  = 16,
  localparam int CNT_W = $clog2(ID_W + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             run_clr,
  output lamp_phase_e      phase_q,
  output lamp_phase_e      phase_d,
  output logic             sclk_d,
  output logic             cap_en,
  output logic [CNT_W-1:0] bit_idx
);
  logic             sclk_q;
  logic [CNT_W-1:0] cnt_q, cnt_d;

  // Shift clock: pin low one cycle, high one cycle; data taken on the rise.
  always_comb begin
    phase_d = phase_q;
    sclk_d  = sclk_q;
    cnt_d   = cnt_q;
    cap_en  = 1'b0;
    case (phase_q)
      PH_IDLE: begin
        phase_d = PH_SHIFT;
        sclk_d  = 1'b0;
        cnt_d   = '0;
      end
      PH_SHIFT: begin
        if (!sclk_q) begin
          sclk_d = 1'b1;
          cap_en = 1'b1;
          cnt_d  = cnt_q + CNT_W'(1);
        end else if (cnt_q == CNT_W'(ID_W)) begin
          phase_d = PH_RUN;
        end else begin
          sclk_d = 1'b0;
        end
      end
      PH_RUN: begin
        if (run_clr) phase_d = PH_ACT;
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      phase_q <= PH_IDLE;
      sclk_q  <= 1'b1;
      cnt_q   <= '0;
    end else begin
      phase_q <= phase_d;
      sclk_q  <= sclk_d;
      cnt_q   <= cnt_d;
    end
  end

  assign bit_idx = cnt_q;
endmodule

// File: rtl/id_capture.sv
module id_capture #(
  parameter int          ID_W       = 16,
  parameter int          MODE_IDX   = 3,
  parameter logic [ID_W-1:0] DEFAULT_ID = 16'h1234,
  localparam int         CNT_W      = $clog2(ID_W + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             cap_en,
  input  logic [CNT_W-1:0] bit_idx,
  input  logic             sdata,
  input  logic             mode_in,
  output logic [ID_W-1:0]  id_q,
  output logic             valid_q,
  output logic             mode_q
);
  logic [ID_W-2:0] shreg;
  logic [ID_W-1:0] shift_d;

  assign shift_d = {shreg, sdata};

  always_ff @(posedge clk) begin
    if (rst) begin
      shreg   <= '0;
      id_q    <= DEFAULT_ID;
      valid_q <= 1'b0;
      mode_q  <= 1'b0;
    end else if (cap_en) begin
      shreg <= shift_d[ID_W-2:0];
      if (bit_idx == CNT_W'(MODE_IDX)) mode_q <= mode_in;
      if (bit_idx == CNT_W'(ID_W - 1)) begin
        id_q    <= shift_d;
        valid_q <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/act_latch.sv
module act_latch #(
  parameter int N_SRC = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [N_SRC-1:0] src,
  input  logic             clr,
  output logic             act_d
);
  logic act_q;
  logic set_any;

  assign set_any = |src;
  // Set wins over a simultaneous bus-free clear.
  assign act_d   = set_any ? 1'b1 : (clr ? 1'b0 : act_q);

  always_ff @(posedge clk) begin
    if (rst) act_q <= 1'b0;
    else     act_q <= act_d;
  end
endmodule

// File: rtl/status_lamp_ctrl.sv
module status_lamp_ctrl
  import lamp_pkg::*;
#(
  parameter int              ID_W       = 16,
  parameter int              MODE_IDX   = 3,
  parameter int              N_SRC      = 3,
  parameter logic [ID_W-1:0] DEFAULT_ID = 16'h1234,
  localparam int             CNT_W      = $clog2(ID_W + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [N_SRC-1:0] sel_flags,
  input  logic             bus_free,
  input  logic             id_sdata,
  input  logic             mode_sel,
  input  logic             sw_run_clr,
  input  logic             sw_gp_en,
  input  logic             sw_gp_val,
  output logic             lamp_n,
  output logic             lamp_oe,
  output logic [ID_W-1:0]  id_value,
  output logic             id_valid,
  output logic             mport_mode,
  output logic             retry
);
  lamp_phase_e      phase_q, phase_d;
  logic             sclk_d;
  logic             cap_en;
  logic [CNT_W-1:0] bit_idx;
  logic             act_d;
  logic             pin_d;

  lamp_seq #(.ID_W(ID_W)) u_seq (
    .clk     (clk),
    .rst     (rst),
    .run_clr (sw_run_clr),
    .phase_q (phase_q),
    .phase_d (phase_d),
    .sclk_d  (sclk_d),
    .cap_en  (cap_en),
    .bit_idx (bit_idx)
  );

  id_capture #(
    .ID_W       (ID_W),
    .MODE_IDX   (MODE_IDX),
    .DEFAULT_ID (DEFAULT_ID)
  ) u_cap (
    .clk     (clk),
    .rst     (rst),
    .cap_en  (cap_en),
    .bit_idx (bit_idx),
    .sdata   (id_sdata),
    .mode_in (mode_sel),
    .id_q    (id_value),
    .valid_q (id_valid),
    .mode_q  (mport_mode)
  );

  act_latch #(.N_SRC(N_SRC)) u_act (
    .clk   (clk),
    .rst   (rst),
    .src   (sel_flags),
    .clr   (bus_free),
    .act_d (act_d)
  );

  always_comb begin
    case (phase_d)
      PH_IDLE:  pin_d = 1'b1;
      PH_SHIFT: pin_d = sclk_d;
      PH_RUN:   pin_d = sw_gp_en ? ~sw_gp_val : 1'b0;
      default:  pin_d = sw_gp_en ? ~sw_gp_val : ~act_d;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      lamp_n  <= 1'b1;
      lamp_oe <= 1'b0;
    end else begin
      lamp_n  <= pin_d;
      lamp_oe <= (phase_d != PH_IDLE);
    end
  end

  assign retry = (phase_q == PH_SHIFT);
endmodule

// File: rtl/lamp_ctrl_chk.sv
module lamp_ctrl_chk
  import lamp_pkg::*;
#(
  parameter int ID_W  = 16,
  parameter int N_SRC = 3
) (
  input logic             clk,
  input logic             rst,
  input logic [N_SRC-1:0] sel_flags,
  input logic             bus_free,
  input logic             sw_gp_en,
  input logic             lamp_n,
  input logic             lamp_oe,
  input logic [ID_W-1:0]  id_value,
  input logic             id_valid,
  input logic             mport_mode,
  input logic             retry,
  input lamp_phase_e      phase_q
);
  logic rst_seen;
  always_ff @(posedge clk) rst_seen <= rst;

  // R1
  float_in_reset_chk: assert property (@(posedge clk) disable iff (!rst_seen)
    rst_seen |-> (!lamp_oe && lamp_n && !retry));

  // R3
  id_hold_chk: assert property (@(posedge clk) disable iff (rst)
    $past(id_valid) |-> (id_valid && $stable(id_value)));

  // R4
  mode_hold_chk: assert property (@(posedge clk) disable iff (rst)
    $past(id_valid) |-> $stable(mport_mode));

  // R5
  retry_end_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(retry) |-> id_valid);

  // R6
  run_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (phase_q == PH_RUN && !$past(sw_gp_en)) |-> !lamp_n);

  // R8
  set_wins_chk: assert property (@(posedge clk) disable iff (rst)
    (phase_q == PH_ACT && (|sel_flags) && bus_free && !sw_gp_en) |=> !lamp_n);

  // R7
  bus_free_clr_chk: assert property (@(posedge clk) disable iff (rst)
    (phase_q == PH_ACT && !(|sel_flags) && bus_free && !sw_gp_en) |=> lamp_n);
endmodule

bind status_lamp_ctrl lamp_ctrl_chk #(.ID_W(ID_W), .N_SRC(N_SRC)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .sel_flags  (sel_flags),
  .bus_free   (bus_free),
  .sw_gp_en   (sw_gp_en),
  .lamp_n     (lamp_n),
  .lamp_oe    (lamp_oe),
  .id_value   (id_value),
  .id_valid   (id_valid),
  .mport_mode (mport_mode),
  .retry      (retry),
  .phase_q    (phase_q)
);

// File: tb/status_lamp_ctrl_test.sv
`timescale 1ns/1ps
module status_lamp_ctrl_test;
  localparam logic [15:0] DEF = 16'h1234;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [2:0]  sel_flags = '0;
  logic        bus_free = 1'b0;
  logic        id_sdata = 1'b0;
  logic        mode_sel = 1'b0;
  logic        sw_run_clr = 1'b0;
  logic        sw_gp_en = 1'b0;
  logic        sw_gp_val = 1'b0;
  logic        lamp_n, lamp_oe, id_valid, mport_mode, retry;
  logic [15:0] id_value;

  int n_chk = 0;
  int n_fail = 0;

  always #2.5 clk = ~clk;

  status_lamp_ctrl #(.DEFAULT_ID(DEF)) uut (
    .clk(clk), .rst(rst), .sel_flags(sel_flags), .bus_free(bus_free),
    .id_sdata(id_sdata), .mode_sel(mode_sel), .sw_run_clr(sw_run_clr),
    .sw_gp_en(sw_gp_en), .sw_gp_val(sw_gp_val), .lamp_n(lamp_n),
    .lamp_oe(lamp_oe), .id_value(id_value), .id_valid(id_valid),
    .mport_mode(mport_mode), .retry(retry)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic t_reset();
    @(negedge clk);
    rst = 1'b1;
    repeat (4) @(negedge clk);
    chk("R1 lamp_oe", {31'b0, lamp_oe}, 0);
    chk("R1 lamp_n", {31'b0, lamp_n}, 1);
    chk("R1 retry", {31'b0, retry}, 0);
    chk("R1 id_valid", {31'b0, id_valid}, 0);
    chk("R1 mport_mode", {31'b0, mport_mode}, 0);
    chk("R1 id_value", {16'b0, id_value}, {16'b0, DEF});
  endtask

  task automatic t_shift(input logic [15:0] idv, input logic m4, input logic gp_on);
    int k = 0;
    int rises = 0;
    int rcnt = 0;
    logic prev = 1'b1;
    sw_gp_en  = gp_on;
    sw_gp_val = 1'b0;
    rst = 1'b0;
    for (int c = 0; c < 40; c++) begin
      @(negedge clk);
      if (retry) rcnt++;
      if (prev == 1'b0 && lamp_n == 1'b1) rises++;
      prev = lamp_n;
      if (k == 8) chk("R3 default before done", {16'b0, id_value}, {16'b0, DEF});
      if (retry && lamp_n == 1'b0 && k < 16) begin
        id_sdata = idv[15-k];
        mode_sel = (k == 3) ? m4 : ~m4;
        k++;
      end
    end
    chk("R2 shift rises", rises, 16);
    chk("R5 retry cycles", rcnt, 32);
    chk("R3 id_value", {16'b0, id_value}, {16'b0, idv});
    chk("R3 id_valid", {31'b0, id_valid}, 1);
    chk("R4 mport_mode", {31'b0, mport_mode}, {31'b0, m4});
    sw_gp_en = 1'b0;
    @(negedge clk);
    chk("R6 run pin low", {31'b0, lamp_n}, 0);
    chk("R2 pin driven", {31'b0, lamp_oe}, 1);
    chk("R5 retry low after", {31'b0, retry}, 0);
  endtask

  task automatic t_run_hold();
    int bad = 0;
    for (int c = 0; c < 10; c++) begin
      sel_flags = 3'(c);
      bus_free  = c[0];
      @(negedge clk);
      if (lamp_n !== 1'b0) bad++;
    end
    chk("R6 hold under activity", bad, 0);
    sel_flags  = '0;
    bus_free   = 1'b1;
    sw_run_clr = 1'b1;
    @(negedge clk);
    bus_free   = 1'b0;
    sw_run_clr = 1'b0;
    chk("R7 lamp off after clear", {31'b0, lamp_n}, 1);
  endtask

  task automatic t_activity(input int b);
    sel_flags[b] = 1'b1;
    @(negedge clk);
    sel_flags = '0;
    chk("R7 lamp set", {31'b0, lamp_n}, 0);
    repeat (5) @(negedge clk);
    chk("R7 lamp latched", {31'b0, lamp_n}, 0);
    bus_free = 1'b1;
    @(negedge clk);
    bus_free = 1'b0;
    chk("R7 lamp released", {31'b0, lamp_n}, 1);
  endtask

  task automatic t_priority();
    sel_flags = 3'b010;
    bus_free  = 1'b1;
    @(negedge clk);
    sel_flags = '0;
    chk("R8 set wins", {31'b0, lamp_n}, 0);
    @(negedge clk);
    bus_free = 1'b0;
    chk("R8 later clear", {31'b0, lamp_n}, 1);
  endtask

  task automatic t_gp();
    sw_gp_en  = 1'b1;
    sw_gp_val = 1'b1;
    @(negedge clk);
    chk("R9 gp lights", {31'b0, lamp_n}, 0);
    sel_flags = 3'b100;
    sw_gp_val = 1'b0;
    @(negedge clk);
    sel_flags = '0;
    chk("R9 gp dark over act", {31'b0, lamp_n}, 1);
    sw_gp_en = 1'b0;
    @(negedge clk);
    chk("R9 gp released", {31'b0, lamp_n}, 0);
    bus_free = 1'b1;
    @(negedge clk);
    bus_free = 1'b0;
  endtask

  initial begin
    #(5.0 * 100000);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    t_reset();
    t_shift(16'hA5C3, 1'b1, 1'b0);
    t_run_hold();
    t_activity(0);
    t_activity(1);
    t_activity(2);
    t_priority();
    t_gp();
    t_reset();
    t_shift(16'h3C96, 1'b0, 1'b1);
    t_run_hold();
    t_activity(1);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule